// File: doc/BRIEF.md
# Stall Protection and Zero-Duty Supervisor

This block sits beside a three-phase brushless gate pre-driver. It watches the three Hall sensor levels and the speed command and decides when the chopped low-side switches may be driven. When the rotor is being driven but no Hall level has changed for a set number of clock cycles, it latches a stall state. While that state is latched, all low-side switches are held off. The latch can be released in four ways: by selecting brake, by flipping the direction input, by a zero-duty command followed by a rising duty, or by an undervoltage reset. An overtemperature event never clears it.

The block also decides when the speed command means zero duty. This happens when the digital command input, which is active low, stays at its off level for a set time, or when the analog comparator reports a command below its zero threshold for the same time. In power-saving mode the block removes the Hall bias supply while the motor is braked, commanded to zero, or stalled. After an undervoltage reset, and after brake has been released, a fixed restart delay must pass before driving resumes. All times are counted in clock cycles and set by parameters: `STALL_CYC` (default 100,000,000), `ZERO_CYC` (default 125,000) and `RESTART_CYC` (default 50,000). The inputs are taken to be already synchronous to `clk`.

Top module: `stall_guard`

## Requirements
- R1: After `rst_n` is released, the outputs are `restart_pend_o`=1, `low_inhibit_o`=1, `stall_o`=0 and `zero_duty_o`=0.
- R2: `zero_duty_o` rises after `ZERO_CYC` consecutive sampled cycles of `pwm_off_i`=1 (1 means the chopped output is off) or of `ana_zero_i`=1. It falls at the first clock edge where neither condition holds. Off pulses shorter than `ZERO_CYC` cycles never raise it.
- R3: The block is driving when it is not stalled, no restart is pending, and brake, zero duty and overtemperature are all inactive. In that state, `stall_o` sets after `STALL_CYC` consecutive cycles with no change on `hall_i`. Any change on `hall_i` restarts the count.
- R4: `low_inhibit_o` is 1 exactly when the block is stalled, a restart is pending, or `ot_i`=1.
- R5: With `psave_i`=1, `hall_bias_en_o` = NOT(`brake_i` OR `zero_duty_o` OR `stall_o`). With `psave_i`=0, `hall_bias_en_o` is held at 1.
- R6: While `restart_pend_o`=1, a count of cycles with `brake_i`=0 and `uv_i`=0 runs. Any cycle with either input at 1 sets the count back to zero. After `RESTART_CYC` such cycles, `restart_pend_o` falls.
- R7: A change of `dir_i` while stalled clears `stall_o` one cycle later, and driving resumes with no restart delay.
- R8: `brake_i`=1 while stalled clears the latch. With `psave_i`=0 driving resumes at once. With `psave_i`=1 the block enters restart pending and the R6 delay applies.
- R9: While stalled, a zero-duty detection followed by the fall of `zero_duty_o` clears the latch.
- R10: `ot_i` never clears the latch. `uv_i`=1 clears the latch and puts the block into restart pending.
- R11: The stall count holds its value while brake, zero duty or overtemperature is active. It is cleared whenever the block is stalled or restart pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hall_i | input | 3 | Hall sensor levels |
| pwm_off_i | input | 1 | Digital speed command, 1 = chopped output off |
| ana_zero_i | input | 1 | Analog command is below its zero-duty threshold |
| brake_i | input | 1 | 1 = brake selected, 0 = start |
| dir_i | input | 1 | Rotation direction level |
| uv_i | input | 1 | Supply undervoltage flag |
| ot_i | input | 1 | Overtemperature shutdown flag |
| psave_i | input | 1 | Power-saving mode selected |
| stall_o | output | 1 | Stall latch state |
| low_inhibit_o | output | 1 | Hold all low-side switches off |
| zero_duty_o | output | 1 | Zero-duty command detected |
| hall_bias_en_o | output | 1 | Hall bias supply enable |
| restart_pend_o | output | 1 | Restart delay in progress |

## Verification
A rotating Hall sequence shows that a timer cleared on every change never trips. A frozen sequence shows that the latch sets after exactly the programmed count. Holding brake, analog zero or overtemperature for longer than the timeout, with the Halls frozen, tells a timer that holds apart from one that keeps counting. Each release path is exercised on its own: direction flip, brake in both power modes, zero-then-rise, and undervoltage. Overtemperature pulses during a stall confirm that it is not a release path. A digital command toggling faster than the zero window checks that short off pulses are ignored.

// File: rtl/stall_guard_pkg.sv
package stall_guard_pkg;
  typedef enum logic [1:0] {
    SG_INIT  = 2'd0,
    SG_RUN   = 2'd1,
    SG_STALL = 2'd2
  } sg_state_e;
endpackage

// File: rtl/sg_change_det.sv
module sg_change_det #(
  parameter int WIDTH = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] lvl_i,
  output logic             chg_o
);
  logic [WIDTH-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= lvl_i;
  end

  assign chg_o = (lvl_i != prev_q);
endmodule

// File: rtl/sg_zero_det.sv
module sg_zero_det #(
  parameter int ZERO_CYC = 125000,
  parameter int NCH      = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] idle_i,
  output logic           zero_o,
  output logic           rise_o
);
  localparam int ZW = $clog2(ZERO_CYC + 1);
  localparam logic [ZW-1:0] ZMAX = ZW'(ZERO_CYC);

  logic [NCH-1:0] sat;
  logic           zero_q;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [ZW-1:0] cnt_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt_q <= '0;
      else if (!idle_i[c])   cnt_q <= '0;
      else if (cnt_q != ZMAX) cnt_q <= cnt_q + 1'b1;
    end
    assign sat[c] = (cnt_q == ZMAX);
  end

  assign zero_o = |sat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) zero_q <= 1'b0;
    else        zero_q <= zero_o;
  end

  assign rise_o = zero_q & ~zero_o;

  // R2: with no idle channel at an edge, zero duty is gone after it
  assert_zero_needs_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_i == '0) |=> !zero_o);
endmodule

// File: rtl/sg_stall_timer.sv
module sg_stall_timer #(
  parameter int STALL_CYC = 100000000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear_i,
  input  logic run_i,
  input  logic hall_chg_i,
  output logic expire_o
);
  localparam int SW = $clog2(STALL_CYC + 1);
  localparam logic [SW-1:0] SLIM = SW'(STALL_CYC - 1);

  logic [SW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= '0;
    else if (clear_i)    cnt_q <= '0;
    else if (hall_chg_i) cnt_q <= '0;
    else if (run_i)      cnt_q <= cnt_q + 1'b1;
  end

  assign expire_o = run_i & ~hall_chg_i & ~clear_i & (cnt_q == SLIM);

  // R11: a frozen timer keeps its count
  assert_freeze_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_i && !clear_i && !hall_chg_i) |=> $stable(cnt_q));
endmodule

// File: rtl/sg_latch_ctrl.sv
module sg_latch_ctrl
  import stall_guard_pkg::*;
#(
  parameter int RESTART_CYC = 50000
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      uv_i,
  input  logic      brake_i,
  input  logic      psave_i,
  input  logic      dir_tog_i,
  input  logic      zero_i,
  input  logic      rise_i,
  input  logic      expire_i,
  output sg_state_e state_o
);
  localparam int RW = $clog2(RESTART_CYC + 1);
  localparam logic [RW-1:0] RLIM = RW'(RESTART_CYC - 1);

  sg_state_e     st_q;
  logic [RW-1:0] rcnt_q;
  logic          arm_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SG_INIT;
      rcnt_q <= '0;
      arm_q  <= 1'b0;
    end else begin
      arm_q <= (st_q == SG_STALL) & (arm_q | zero_i);
      case (st_q)
        SG_INIT: begin
          if (uv_i || brake_i) rcnt_q <= '0;
          else if (rcnt_q == RLIM) begin
            st_q   <= SG_RUN;
            rcnt_q <= '0;
          end else rcnt_q <= rcnt_q + 1'b1;
        end
        SG_RUN: begin
          rcnt_q <= '0;
          if (uv_i)          st_q <= SG_INIT;
          else if (expire_i) st_q <= SG_STALL;
        end
        SG_STALL: begin
          rcnt_q <= '0;
          if (uv_i)                              st_q <= SG_INIT;
          else if (brake_i)                      st_q <= psave_i ? SG_INIT : SG_RUN;
          else if (dir_tog_i || (arm_q && rise_i)) st_q <= SG_RUN;
        end
        default: begin
          st_q   <= SG_INIT;
          rcnt_q <= '0;
        end
      endcase
    end
  end

  assign state_o = st_q;

  // R10: undervoltage always lands in restart pending
  assert_uv_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
    uv_i |=> (st_q == SG_INIT));
  // R7: direction flip releases a stall straight to driving
  assert_dir_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SG_STALL && dir_tog_i && !uv_i && !brake_i) |=> (st_q == SG_RUN));
  // R8: brake in power-saving mode releases into the restart delay
  assert_brake_psave_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SG_STALL && brake_i && psave_i && !uv_i) |=> (st_q == SG_INIT));
  // R10: with no release cause the latch holds, whatever the temperature
  assert_latch_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SG_STALL && !uv_i && !brake_i && !dir_tog_i && !(arm_q && rise_i))
      |=> (st_q == SG_STALL));
endmodule

// File: rtl/stall_guard.sv
module stall_guard
  import stall_guard_pkg::*;
#(
  parameter int STALL_CYC   = 100000000,
  parameter int ZERO_CYC    = 125000,
  parameter int RESTART_CYC = 50000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] hall_i,
  input  logic       pwm_off_i,
  input  logic       ana_zero_i,
  input  logic       brake_i,
  input  logic       dir_i,
  input  logic       uv_i,
  input  logic       ot_i,
  input  logic       psave_i,
  output logic       stall_o,
  output logic       low_inhibit_o,
  output logic       zero_duty_o,
  output logic       hall_bias_en_o,
  output logic       restart_pend_o
);
  logic      hall_chg, dir_tog, zero, rise, expire, run;
  sg_state_e st;

  sg_change_det #(.WIDTH(3)) u_hall_chg (
    .clk(clk), .rst_n(rst_n), .lvl_i(hall_i), .chg_o(hall_chg));

  sg_change_det #(.WIDTH(1)) u_dir_chg (
    .clk(clk), .rst_n(rst_n), .lvl_i(dir_i), .chg_o(dir_tog));

  sg_zero_det #(.ZERO_CYC(ZERO_CYC), .NCH(2)) u_zero (
    .clk(clk), .rst_n(rst_n), .idle_i({ana_zero_i, pwm_off_i}),
    .zero_o(zero), .rise_o(rise));

  assign run = (st == SG_RUN) & ~brake_i & ~zero & ~ot_i;

  sg_stall_timer #(.STALL_CYC(STALL_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .clear_i(st != SG_RUN), .run_i(run),
    .hall_chg_i(hall_chg), .expire_o(expire));

  sg_latch_ctrl #(.RESTART_CYC(RESTART_CYC)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .uv_i(uv_i), .brake_i(brake_i), .psave_i(psave_i),
    .dir_tog_i(dir_tog), .zero_i(zero), .rise_i(rise), .expire_i(expire),
    .state_o(st));

  assign stall_o        = (st == SG_STALL);
  assign restart_pend_o = (st == SG_INIT);
  assign zero_duty_o    = zero;
  assign low_inhibit_o  = stall_o | restart_pend_o | ot_i;
  assign hall_bias_en_o = psave_i ? ~(brake_i | zero | stall_o) : 1'b1;

  // R4: a latched stall always holds the low side off
  assert_inhibit_on_stall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    stall_o |-> low_inhibit_o);
  // R3: a new stall can only come out of the driving state
  assert_stall_from_drive_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stall_o) |-> $past(!restart_pend_o && !brake_i && !ot_i));
endmodule

// File: tb/stall_guard_tb.sv
module stall_guard_tb;
  localparam int S = 200;
  localparam int Z = 20;
  localparam int R = 30;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] hall = 3'd1;
  logic pwm_off = 0, ana_zero = 0, brake = 0, dir = 0, uv = 0, ot = 0, psave = 1;
  logic stall, inhibit, zero, bias, pend;

  int vectors = 0;
  int miscompares = 0;
  string cur_req = "R1";
  bit done = 0;

  always #10 clk = ~clk;

  stall_guard #(.STALL_CYC(S), .ZERO_CYC(Z), .RESTART_CYC(R)) u_dut (
    .clk(clk), .rst_n(rst_n), .hall_i(hall), .pwm_off_i(pwm_off),
    .ana_zero_i(ana_zero), .brake_i(brake), .dir_i(dir), .uv_i(uv), .ot_i(ot),
    .psave_i(psave), .stall_o(stall), .low_inhibit_o(inhibit),
    .zero_duty_o(zero), .hall_bias_en_o(bias), .restart_pend_o(pend));

  // behavioural reference: mode 0 waiting, 1 driving, 2 stalled
  int m_mode, m_rc, m_sc, m_zp, m_za, m_hprev, m_dprev;
  bit m_zprev, m_arm;

  function automatic bit m_zero();
    return (m_zp >= Z) || (m_za >= Z);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 0; m_rc = 0; m_sc = 0; m_zp = 0; m_za = 0;
      m_hprev = 0; m_dprev = 0; m_zprev = 0; m_arm = 0;
    end else begin
      bit z, hc, dt, rs, drv, exp_t;
      int nmode;
      z  = m_zero();
      hc = (int'(hall) != m_hprev);
      dt = (int'(dir) != m_dprev);
      rs = m_zprev && !z;
      drv = (m_mode == 1) && !brake && !z && !ot;
      exp_t = drv && !hc && (m_sc == S - 1);
      nmode = m_mode;
      if (m_mode == 0) begin
        if (uv || brake) m_rc = 0;
        else if (m_rc == R - 1) begin nmode = 1; m_rc = 0; end
        else m_rc++;
      end else if (m_mode == 1) begin
        if (uv) nmode = 0; else if (exp_t) nmode = 2;
      end else begin
        if (uv) nmode = 0;
        else if (brake) nmode = psave ? 0 : 1;
        else if (dt || (m_arm && rs)) nmode = 1;
      end
      if (m_mode != 1) m_sc = 0;
      else if (hc) m_sc = 0;
      else if (drv) m_sc++;
      m_arm = (m_mode == 2) && (m_arm || z);
      m_zp = pwm_off ? ((m_zp < Z) ? m_zp + 1 : Z) : 0;
      m_za = ana_zero ? ((m_za < Z) ? m_za + 1 : Z) : 0;
      m_zprev = z;
      m_hprev = int'(hall);
      m_dprev = int'(dir);
      m_mode = nmode;
    end
  end

  task automatic cmp1(string what, logic act, bit expv);
    vectors++;
    if (act !== expv) begin
      miscompares++;
      $display("FAIL %s %s at %0t: actual %b expected %b", cur_req, what, $time, act, expv);
    end
  endtask

  task automatic step(int n);
    for (int i = 0; i < n; i++) begin
      bit es, ez;
      @(negedge clk);
      es = (m_mode == 2);
      ez = m_zero();
      cmp1("stall", stall, es);
      cmp1("restart", pend, m_mode == 0);
      cmp1("zero", zero, ez);
      cmp1("inhibit", inhibit, es || (m_mode == 0) || ot);
      cmp1("bias", bias, psave ? !(brake || ez || es) : 1'b1);
    end
  endtask

  task automatic chk(string req, string what, logic act, logic expv);
    vectors++;
    if (act !== expv) begin
      miscompares++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, expv);
    end
  endtask

  function automatic logic [2:0] hcode(int k);
    case (k % 6)
      0: return 3'd1; 1: return 3'd3; 2: return 3'd2;
      3: return 3'd6; 4: return 3'd4; default: return 3'd5;
    endcase
  endfunction

  task automatic rotate(int steps, int dwell);
    for (int k = 0; k < steps; k++) begin
      hall = hcode(k);
      step(dwell);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  initial begin
    #(20 * 200000);
    miscompares++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cur_req = "R1"; step(1);
    chk("R1", "restart after reset", pend, 1'b1);
    chk("R1", "stall after reset", stall, 1'b0);
    chk("R1", "inhibit after reset", inhibit, 1'b1);
    chk("R1", "zero after reset", zero, 1'b0);

    cur_req = "R6"; step(R + 5);
    chk("R6", "restart delay over", pend, 1'b0);

    cur_req = "R3"; rotate(30, 40);
    chk("R3", "no stall while rotating", stall, 1'b0);
    step(S + 10);
    chk("R3", "stall after timeout", stall, 1'b1);
    chk("R4", "inhibit while stalled", inhibit, 1'b1);
    chk("R5", "bias off when stalled", bias, 1'b0);

    cur_req = "R10"; ot = 1; step(5);
    chk("R4", "inhibit on overtemp", inhibit, 1'b1);
    ot = 0; step(5);
    chk("R10", "overtemp keeps latch", stall, 1'b1);

    cur_req = "R7"; dir = 1; step(2);
    chk("R7", "dir releases", stall, 1'b0);
    chk("R7", "no restart delay", pend, 1'b0);

    cur_req = "R11"; brake = 1; step(S * 2);
    chk("R11", "no stall under brake", stall, 1'b0);
    chk("R5", "bias off under brake", bias, 1'b0);
    brake = 0; step(S + 10);
    chk("R11", "timer resumes", stall, 1'b1);

    cur_req = "R9"; pwm_off = 1; step(Z + 5);
    chk("R2", "digital zero detected", zero, 1'b1);
    chk("R9", "still latched at zero", stall, 1'b1);
    pwm_off = 0; step(2);
    chk("R9", "rise releases", stall, 1'b0);
    chk("R2", "zero cleared", zero, 1'b0);

    cur_req = "R2"; ana_zero = 1; step(Z + 5);
    chk("R2", "analog zero detected", zero, 1'b1);
    step(S * 2);
    chk("R11", "no stall at zero duty", stall, 1'b0);
    ana_zero = 0; step(S + 10);
    chk("R3", "stall after analog zero", stall, 1'b1);

    cur_req = "R8"; psave = 0; step(1);
    chk("R5", "bias held without power saving", bias, 1'b1);
    brake = 1; step(2);
    chk("R8", "brake releases", stall, 1'b0);
    chk("R8", "no delay without power saving", pend, 1'b0);
    brake = 0; step(S + 10);
    chk("R3", "stall again", stall, 1'b1);
    psave = 1; brake = 1; step(10);
    chk("R8", "brake in power saving releases", stall, 1'b0);
    chk("R8", "restart pending after brake", pend, 1'b1);
    brake = 0; step(10);
    chk("R6", "delay still running", pend, 1'b1);
    step(R);
    chk("R6", "delay done", pend, 1'b0);

    cur_req = "R10"; rotate(6, 30); step(S + 10);
    chk("R3", "stall before undervoltage", stall, 1'b1);
    uv = 1; step(3);
    chk("R10", "undervoltage clears latch", stall, 1'b0);
    chk("R10", "undervoltage restart", pend, 1'b1);
    uv = 0; step(R + 5);
    chk("R6", "restart after undervoltage", pend, 1'b0);

    cur_req = "R2";
    for (int k = 0; k < 20; k++) begin
      pwm_off = ~pwm_off;
      hall = hcode(k);
      step(Z / 2);
      chk("R2", "short off pulses ignored", zero, 1'b0);
    end
    pwm_off = 0; step(3);
    finish_run();
  end
endmodule